// File: doc/BRIEF.md
# USB Function Token and Handshake Engine

This block sits behind the receive path of a USB function, after line decoding, bit unstuffing and data CRC checking. It takes the bytes of each received packet, with a start marker on the first byte and a separate end marker after the last, and does three things. It checks the packet identifier. It decodes and verifies token packets. It decides the handshake the function returns for each transaction. The rest of the device receives single-cycle strobes that say when buffered OUT data is accepted as new, when an 8-byte setup request has arrived, when an IN request should start a data transmission, and when a start-of-frame number has arrived.

The engine keeps one expected data-toggle bit per endpoint. It uses these bits to tell a retransmitted data packet from a new one. A retransmission is acknowledged so that the host moves on, but it is not reported as new data. Endpoint ready and halt flags come from the surrounding function logic. A separate bus-reset input returns all toggles to their initial state without a full block reset. The block reset is asynchronous and active-low, and its release is expected to be synchronised upstream.

Top module: `usb_tok_hs_engine`

## Requirements
- R1: The first byte of a packet carries the 4-bit identifier code in bits 3:0 and its bitwise complement in bits 7:4. A packet whose upper nibble is not the complement of its lower nibble, or a packet with no bytes, produces no response and ends any pending transaction.
- R2: A token (OUT 0001, IN 1001, SETUP 1101) is acted on only when the packet has exactly 3 bytes, payload bits 6:0 (byte 1 bit 0 = payload bit 0, byte 2 = payload bits 15:8) equal dev_addr, the endpoint number in payload bits 10:7 is below NUM_EP, and the check field in payload bits 15:11 is correct. The check is the inverted remainder of x^5+x^2+1 over payload bits 0 to 10 in that order, with the remainder preset to all ones, and remainder bit 4 sits at payload bit 11. Any other token produces no response.
- R3: A 3-byte start-of-frame packet (code 0101) with a correct check field pulses sof_valid and loads payload bits 10:0 into sof_frame, with no address check. sof_frame holds its value until the next such packet.
- R4: A DATA0 (0011) or DATA1 (1011) packet that directly follows an accepted OUT token is answered in this order of priority: no response if rx_crc16_ok is low; STALL (1110) if the endpoint is halted; ACK (0010) if the packet is a duplicate; NAK (1010) if the endpoint is not ready; otherwise ACK together with data_accept.
- R5: A data packet whose type differs from the endpoint's expected toggle is a duplicate: it is acknowledged without data_accept and the toggle is unchanged. A packet that is accepted flips that endpoint's toggle.
- R6: A data packet with rx_crc16_ok low produces no handshake and no strobe and leaves the toggle unchanged.
- R7: An accepted IN token answers STALL if the endpoint is halted and NAK if it is not ready. Otherwise it pulses in_start with no handshake. xfer_ep carries the token's endpoint number.
- R8: An accepted SETUP token sets that endpoint's toggle to DATA0. A following DATA0 of exactly 8 data bytes with rx_crc16_ok high is answered ACK with setup_capture, regardless of ready or halt, and sets the toggle to DATA1. Any other following data packet produces no response.
- R9: A one-cycle usb_reset pulse clears every endpoint toggle to DATA0 and abandons any pending transaction.
- R10: Responses appear in the second clock cycle after the cycle in which rx_eop is sampled and last one cycle. hs_pid is zero whenever hs_valid is low.
- R11: After reset every strobe and hs_valid are low, sof_frame is zero and all toggles expect DATA0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usb_reset | input | 1 | Bus reset pulse; clears toggles |
| rx_valid | input | 1 | A packet byte is present on rx_data |
| rx_sop | input | 1 | With rx_valid: this byte is the identifier byte |
| rx_data | input | 8 | Packet byte, CRC16 bytes excluded |
| rx_eop | input | 1 | End of packet, in a cycle after the last byte |
| rx_crc16_ok | input | 1 | Data CRC result, sampled with rx_eop |
| dev_addr | input | 7 | Assigned device address |
| ep_ready | input | NUM_EP | Per endpoint: OUT buffer free / IN data available |
| ep_stall | input | NUM_EP | Per endpoint halt flag |
| hs_valid | output | 1 | Send a handshake |
| hs_pid | output | 4 | Handshake code to send |
| in_start | output | 1 | Start an IN data packet |
| xfer_ep | output | 4 | Endpoint of the current token |
| data_accept | output | 1 | Buffered OUT data is new; commit it |
| setup_capture | output | 1 | Buffered 8-byte setup request is valid |
| sof_valid | output | 1 | Start-of-frame received |
| sof_frame | output | 11 | Last received frame number |

## Verification
The bound checker watches on every cycle that handshakes only carry ACK, NAK or STALL codes, and that data_accept and setup_capture always come with an ACK. It also checks that an IN start never comes with a handshake, that sof_frame moves only with sof_valid, that an accepted packet flips exactly one toggle, and that a bus reset empties the toggle bank. Some behaviour depends on packet history and can only be shown by the bench scenarios. This covers the handshake priority across sequences of retransmissions, rejection of corrupt identifiers, foreign addresses, bad check fields and out-of-range endpoints, and the toggle forcing done by SETUP and by bus reset.

// File: rtl/usbtk_pkg.sv
package usbtk_pkg;
  localparam logic [3:0] CODE_OUT   = 4'b0001;
  localparam logic [3:0] CODE_IN    = 4'b1001;
  localparam logic [3:0] CODE_SOF   = 4'b0101;
  localparam logic [3:0] CODE_SETUP = 4'b1101;
  localparam logic [3:0] CODE_DATA0 = 4'b0011;
  localparam logic [3:0] CODE_DATA1 = 4'b1011;
  localparam logic [3:0] CODE_ACK   = 4'b0010;
  localparam logic [3:0] CODE_NAK   = 4'b1010;
  localparam logic [3:0] CODE_STALL = 4'b1110;

  localparam int TOKEN_FIELD_BITS = 11;
  localparam int CHECK_BITS       = 5;
  localparam logic [CHECK_BITS-1:0] CHECK_POLY = 5'b00101;

  typedef enum logic [1:0] {
    XS_IDLE,
    XS_OUT_DATA,
    XS_SETUP_DATA
  } xact_state_e;
endpackage

// File: rtl/usbtk_rx_collect.sv
module usbtk_rx_collect #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic             rx_sop,
  input  logic [7:0]       rx_data,
  input  logic             rx_eop,
  input  logic             rx_crc16_ok,
  output logic             pkt_done,
  output logic [7:0]       pkt_pid,
  output logic [15:0]      pkt_payload,
  output logic [LEN_W-1:0] pkt_len,
  output logic             pkt_crc_ok
);
  localparam logic [LEN_W-1:0] CNT_MAX = '1;
  localparam logic [LEN_W-1:0] CNT_ONE = LEN_W'(1);
  localparam logic [LEN_W-1:0] CNT_TWO = LEN_W'(2);

  logic [LEN_W-1:0] cnt_q, cnt_n, len_q, len_n;
  logic [7:0]       pid_q, pid_n, lo_q, lo_n, hi_q, hi_n;
  logic             crc_q, crc_n, done_q;
  logic             byte_en, close_en;

  assign byte_en  = rx_valid && (rx_sop || cnt_q != '0);
  assign close_en = rx_eop;

  always_comb begin
    cnt_n = cnt_q;
    pid_n = pid_q;
    lo_n  = lo_q;
    hi_n  = hi_q;
    len_n = len_q;
    crc_n = crc_q;
    if (close_en) begin
      len_n = cnt_q;
      crc_n = rx_crc16_ok;
      cnt_n = '0;
    end else if (byte_en) begin
      if (rx_sop) begin
        pid_n = rx_data;
        cnt_n = CNT_ONE;
      end else begin
        if (cnt_q == CNT_ONE) lo_n = rx_data;
        if (cnt_q == CNT_TWO) hi_n = rx_data;
        if (cnt_q != CNT_MAX) cnt_n = cnt_q + CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pid_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      len_q  <= '0;
      crc_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= close_en;
      if (close_en || byte_en) begin
        cnt_q <= cnt_n;
        pid_q <= pid_n;
        lo_q  <= lo_n;
        hi_q  <= hi_n;
        len_q <= len_n;
        crc_q <= crc_n;
      end
    end
  end

  assign pkt_done    = done_q;
  assign pkt_pid     = pid_q;
  assign pkt_payload = {hi_q, lo_q};
  assign pkt_len     = len_q;
  assign pkt_crc_ok  = crc_q;
endmodule

// File: rtl/usbtk_crc5.sv
module usbtk_crc5
  import usbtk_pkg::*;
(
  input  logic [TOKEN_FIELD_BITS-1:0] field_bits,
  output logic [CHECK_BITS-1:0]       check_field
);
  logic [CHECK_BITS-1:0] rem;
  logic                  fb;

  always_comb begin
    rem = '1;
    fb  = 1'b0;
    for (int i = 0; i < TOKEN_FIELD_BITS; i++) begin
      fb  = field_bits[i] ^ rem[CHECK_BITS-1];
      rem = {rem[CHECK_BITS-2:0], 1'b0} ^ (fb ? CHECK_POLY : '0);
    end
    for (int j = 0; j < CHECK_BITS; j++) begin
      check_field[j] = ~rem[CHECK_BITS-1-j];
    end
  end
endmodule

// File: rtl/usbtk_toggle_bank.sv
module usbtk_toggle_bank #(
  parameter int NUM_EP   = 4,
  parameter int SEL_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic              wr_val,
  output logic [NUM_EP-1:0] tog
);
  generate
    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
      logic bit_q, bit_n, bit_en;

      assign bit_en = clr_all || (wr_en && wr_sel == SEL_W'(e));

      always_comb begin
        bit_n = clr_all ? 1'b0 : wr_val;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bit_q <= 1'b0;
        end else if (bit_en) begin
          bit_q <= bit_n;
        end
      end

      assign tog[e] = bit_q;
    end
  endgenerate
endmodule

// File: rtl/usb_tok_hs_engine.sv
module usb_tok_hs_engine
  import usbtk_pkg::*;
#(
  parameter int NUM_EP      = 4,
  parameter int LEN_W       = 4,
  parameter int SETUP_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              usb_reset,
  input  logic              rx_valid,
  input  logic              rx_sop,
  input  logic [7:0]        rx_data,
  input  logic              rx_eop,
  input  logic              rx_crc16_ok,
  input  logic [6:0]        dev_addr,
  input  logic [NUM_EP-1:0] ep_ready,
  input  logic [NUM_EP-1:0] ep_stall,
  output logic              hs_valid,
  output logic [3:0]        hs_pid,
  output logic              in_start,
  output logic [3:0]        xfer_ep,
  output logic              data_accept,
  output logic              setup_capture,
  output logic              sof_valid,
  output logic [10:0]       sof_frame
);
  localparam int EP_IDX_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1;
  localparam logic [4:0]       EP_LIMIT  = 5'(NUM_EP);
  localparam logic [LEN_W-1:0] TOK_LEN   = LEN_W'(3);
  localparam logic [LEN_W-1:0] SETUP_LEN = LEN_W'(SETUP_BYTES + 1);

  logic             pkt_done, pkt_crc_ok;
  logic [7:0]       pkt_pid;
  logic [15:0]      pkt_payload;
  logic [LEN_W-1:0] pkt_len;

  usbtk_rx_collect #(.LEN_W(LEN_W)) u_collect (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_data(rx_data),
    .rx_eop(rx_eop), .rx_crc16_ok(rx_crc16_ok),
    .pkt_done(pkt_done), .pkt_pid(pkt_pid), .pkt_payload(pkt_payload),
    .pkt_len(pkt_len), .pkt_crc_ok(pkt_crc_ok)
  );

  logic [CHECK_BITS-1:0] calc_check;

  usbtk_crc5 u_crc5 (
    .field_bits(pkt_payload[TOKEN_FIELD_BITS-1:0]),
    .check_field(calc_check)
  );

  logic                tog_wr, tog_val;
  logic [EP_IDX_W-1:0] tog_sel;
  logic [NUM_EP-1:0]   tog_vec;

  usbtk_toggle_bank #(.NUM_EP(NUM_EP), .SEL_W(EP_IDX_W)) u_toggles (
    .clk(clk), .rst_n(rst_n), .clr_all(usb_reset),
    .wr_en(tog_wr), .wr_sel(tog_sel), .wr_val(tog_val), .tog(tog_vec)
  );

  // decoded view of the collected packet
  logic [3:0]          code;
  logic                pid_ok, tok_ok, tok_mine;
  logic [3:0]          tok_ep;
  logic [EP_IDX_W-1:0] tok_idx, cur_idx;

  assign code     = pkt_pid[3:0];
  assign pid_ok   = (pkt_pid[7:4] == ~pkt_pid[3:0]) && (pkt_len != '0);
  assign tok_ok   = (pkt_len == TOK_LEN) &&
                    (calc_check == pkt_payload[15:11]);
  assign tok_ep   = pkt_payload[10:7];
  assign tok_mine = tok_ok && (pkt_payload[6:0] == dev_addr) &&
                    ({1'b0, tok_ep} < EP_LIMIT);
  assign tok_idx  = tok_ep[EP_IDX_W-1:0];

  xact_state_e st_q, st_n;
  logic [3:0]  ep_q, ep_n;
  logic        hs_v_q, hs_v_n, acc_q, acc_n, setup_q, setup_n;
  logic        in_q, in_n, sofv_q, sofv_n;
  logic [3:0]  hs_pid_q, hs_pid_n;
  logic [10:0] frame_q, frame_n;

  assign cur_idx = ep_q[EP_IDX_W-1:0];

  always_comb begin
    st_n     = st_q;
    ep_n     = ep_q;
    hs_v_n   = 1'b0;
    hs_pid_n = '0;
    acc_n    = 1'b0;
    setup_n  = 1'b0;
    in_n     = 1'b0;
    sofv_n   = 1'b0;
    frame_n  = frame_q;
    tog_wr   = 1'b0;
    tog_sel  = cur_idx;
    tog_val  = 1'b0;

    if (usb_reset) begin
      st_n = XS_IDLE;
    end else if (pkt_done) begin
      st_n = XS_IDLE;
      if (pid_ok) begin
        case (code)
          CODE_OUT, CODE_IN, CODE_SETUP: begin
            if (tok_mine) begin
              ep_n = tok_ep;
              if (code == CODE_OUT) begin
                st_n = XS_OUT_DATA;
              end else if (code == CODE_SETUP) begin
                st_n    = XS_SETUP_DATA;
                tog_wr  = 1'b1;
                tog_sel = tok_idx;
                tog_val = 1'b0;
              end else if (ep_stall[tok_idx]) begin
                hs_v_n   = 1'b1;
                hs_pid_n = CODE_STALL;
              end else if (ep_ready[tok_idx]) begin
                in_n = 1'b1;
              end else begin
                hs_v_n   = 1'b1;
                hs_pid_n = CODE_NAK;
              end
            end
          end
          CODE_SOF: begin
            if (tok_ok) begin
              sofv_n  = 1'b1;
              frame_n = pkt_payload[10:0];
            end
          end
          CODE_DATA0, CODE_DATA1: begin
            if (st_q == XS_OUT_DATA && pkt_crc_ok) begin
              hs_v_n = 1'b1;
              if (ep_stall[cur_idx]) begin
                hs_pid_n = CODE_STALL;
              end else if (code[3] != tog_vec[cur_idx]) begin
                hs_pid_n = CODE_ACK;
              end else if (!ep_ready[cur_idx]) begin
                hs_pid_n = CODE_NAK;
              end else begin
                hs_pid_n = CODE_ACK;
                acc_n    = 1'b1;
                tog_wr   = 1'b1;
                tog_val  = ~tog_vec[cur_idx];
              end
            end else if (st_q == XS_SETUP_DATA && pkt_crc_ok &&
                         code == CODE_DATA0 && pkt_len == SETUP_LEN) begin
              hs_v_n   = 1'b1;
              hs_pid_n = CODE_ACK;
              setup_n  = 1'b1;
              tog_wr   = 1'b1;
              tog_val  = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= XS_IDLE;
      ep_q     <= '0;
      hs_v_q   <= 1'b0;
      hs_pid_q <= '0;
      acc_q    <= 1'b0;
      setup_q  <= 1'b0;
      in_q     <= 1'b0;
      sofv_q   <= 1'b0;
      frame_q  <= '0;
    end else begin
      st_q     <= st_n;
      ep_q     <= ep_n;
      hs_v_q   <= hs_v_n;
      hs_pid_q <= hs_pid_n;
      acc_q    <= acc_n;
      setup_q  <= setup_n;
      in_q     <= in_n;
      sofv_q   <= sofv_n;
      if (sofv_n) frame_q <= frame_n;
    end
  end

  assign hs_valid      = hs_v_q;
  assign hs_pid        = hs_pid_q;
  assign in_start      = in_q;
  assign xfer_ep       = ep_q;
  assign data_accept   = acc_q;
  assign setup_capture = setup_q;
  assign sof_valid     = sofv_q;
  assign sof_frame     = frame_q;
endmodule

// File: rtl/usbtk_chk.sv
module usbtk_chk #(
  parameter int NUM_EP = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              usb_reset,
  input logic              hs_valid,
  input logic [3:0]        hs_pid,
  input logic              in_start,
  input logic              data_accept,
  input logic              setup_capture,
  input logic              sof_valid,
  input logic [10:0]       sof_frame,
  input logic [NUM_EP-1:0] tog
);
  AST_HS_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid |-> (hs_pid == 4'b0010 || hs_pid == 4'b1010 || hs_pid == 4'b1110)); // R10

  AST_HS_PID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_valid |-> hs_pid == 4'b0000); // R10

  AST_ACCEPT_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    data_accept |-> (hs_valid && hs_pid == 4'b0010)); // R4

  AST_SETUP_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    setup_capture |-> (hs_valid && hs_pid == 4'b0010)); // R8

  AST_IN_NO_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    in_start |-> !hs_valid); // R7

  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sof_valid |-> $stable(sof_frame)); // R3

  AST_ACCEPT_FLIPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    data_accept |-> $countones(tog ^ $past(tog)) == 1); // R5

  AST_BUS_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    usb_reset |=> tog == '0); // R9
endmodule

bind usb_tok_hs_engine usbtk_chk #(.NUM_EP(NUM_EP)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .usb_reset(usb_reset),
  .hs_valid(hs_valid),
  .hs_pid(hs_pid),
  .in_start(in_start),
  .data_accept(data_accept),
  .setup_capture(setup_capture),
  .sof_valid(sof_valid),
  .sof_frame(sof_frame),
  .tog(tog_vec)
);

// File: tb/sim_usb_tok_hs_engine.sv
`timescale 1ns/1ps
module sim_usb_tok_hs_engine;
  localparam int NEP = 4;
  localparam logic [3:0] C_OUT = 4'b0001, C_IN = 4'b1001, C_SOF = 4'b0101,
                         C_SETUP = 4'b1101, C_D0 = 4'b0011, C_D1 = 4'b1011,
                         C_ACK = 4'b0010, C_NAK = 4'b1010, C_STALL = 4'b1110;
  localparam logic [6:0] MY_ADDR = 7'h2A;

  // {ready, stall, crc_ok, data1, exp_hs, exp_pid[3:0], exp_accept}, endpoint 1
  localparam logic [9:0] VEC [10] = '{
    10'b1_0_1_0_1_0010_1,
    10'b1_0_1_0_1_0010_0,
    10'b1_0_0_1_0_0000_0,
    10'b0_0_1_1_1_1010_0,
    10'b1_1_1_1_1_1110_0,
    10'b1_0_1_1_1_0010_1,
    10'b1_0_1_1_1_0010_0,
    10'b1_1_1_0_1_1110_0,
    10'b0_0_1_1_1_0010_0,
    10'b1_0_1_0_1_0010_1
  };

  logic clk = 1'b0;
  logic rst_n, usb_reset, rx_valid, rx_sop, rx_eop, rx_crc16_ok;
  logic [7:0] rx_data;
  logic [6:0] dev_addr;
  logic [NEP-1:0] ep_ready, ep_stall;
  logic hs_valid, in_start, data_accept, setup_capture, sof_valid;
  logic [3:0] hs_pid, xfer_ep;
  logic [10:0] sof_frame;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  usb_tok_hs_engine #(.NUM_EP(NEP)) u0 (
    .clk(clk), .rst_n(rst_n), .usb_reset(usb_reset),
    .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_data(rx_data),
    .rx_eop(rx_eop), .rx_crc16_ok(rx_crc16_ok), .dev_addr(dev_addr),
    .ep_ready(ep_ready), .ep_stall(ep_stall),
    .hs_valid(hs_valid), .hs_pid(hs_pid), .in_start(in_start),
    .xfer_ep(xfer_ep), .data_accept(data_accept),
    .setup_capture(setup_capture), .sof_valid(sof_valid),
    .sof_frame(sof_frame)
  );

  function automatic logic [4:0] chk_field(input logic [10:0] bits);
    int r = 31;
    int top;
    logic [4:0] inv;
    logic [4:0] f;
    for (int i = 0; i < 11; i++) begin
      top = (r >> 4) & 1;
      r = (r << 1) & 31;
      if (top != int'(bits[i])) r = r ^ 5;
    end
    inv = 5'(r) ^ 5'h1f;
    for (int i = 0; i < 5; i++) f[i] = inv[4 - i];
    return f;
  endfunction

  function automatic logic [7:0] resp();
    return {hs_valid, hs_pid, data_accept, setup_capture, in_start};
  endfunction

  function automatic logic [7:0] mk(input logic hs, input logic [3:0] pid,
                                    input logic acc, input logic su,
                                    input logic ins);
    return {hs, pid, acc, su, ins};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_pkt(input logic [7:0] pid_b, input int nb,
                          input logic [15:0] pl, input logic crc_ok);
    @(negedge clk);
    rx_valid = 1'b1; rx_sop = 1'b1; rx_data = pid_b;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      rx_sop = 1'b0;
      rx_data = (i == 0) ? pl[7:0] : (i == 1) ? pl[15:8] : 8'(i * 17);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b1; rx_crc16_ok = crc_ok;
    @(negedge clk);
    rx_eop = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_token(input logic [3:0] c, input logic [6:0] a,
                            input logic [3:0] ep, input logic corrupt);
    logic [10:0] f;
    logic [4:0] k;
    f = {ep, a};
    k = chk_field(f) ^ {4'b0, corrupt};
    send_pkt({~c, c}, 2, {k, f}, 1'b1);
  endtask

  task automatic send_data(input logic [3:0] c, input int n, input logic ok);
    send_pkt({~c, c}, n, 16'h0000, ok);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; usb_reset = 1'b0; rx_valid = 1'b0; rx_sop = 1'b0;
    rx_eop = 1'b0; rx_crc16_ok = 1'b0; rx_data = '0;
    dev_addr = MY_ADDR; ep_ready = '1; ep_stall = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset strobes", {24'b0, resp()}, 32'(mk(0, 4'h0, 0, 0, 0)));
    chk("R11 reset frame", {21'b0, sof_valid, sof_frame}, 32'h0);

    // table walk: OUT transactions on endpoint 1 (R4 R5 R6)
    for (int k = 0; k < 10; k++) begin
      logic [9:0] v;
      v = VEC[k];
      ep_ready[1] = v[9];
      ep_stall[1] = v[8];
      send_token(C_OUT, MY_ADDR, 4'd1, 1'b0);
      chk("R2 OUT token quiet", {24'b0, resp()}, 32'h0);
      send_data(v[6] ? C_D1 : C_D0, 4, v[7]);
      chk($sformatf("R4 R5 R6 vector %0d", k), {24'b0, resp()},
          32'(mk(v[5], v[4:1], v[0], 1'b0, 1'b0)));
      if (k == 0) begin
        @(negedge clk);
        chk("R10 one-cycle response", {24'b0, resp()}, 32'h0);
      end
    end
    ep_ready = '1; ep_stall = '0;
    // endpoint 1 now expects DATA1

    // R1 corrupted identifier byte on an OUT token
    send_pkt({4'b1111, C_OUT}, 2, {chk_field({4'd1, MY_ADDR}), 4'd1, MY_ADDR}, 1'b1);
    send_data(C_D1, 4, 1'b1);
    chk("R1 bad identifier ignored", {24'b0, resp()}, 32'h0);

    // R2 foreign address, bad check field, endpoint out of range
    send_token(C_OUT, 7'h2B, 4'd1, 1'b0);
    send_data(C_D1, 4, 1'b1);
    chk("R2 foreign address", {24'b0, resp()}, 32'h0);
    send_token(C_OUT, MY_ADDR, 4'd1, 1'b1);
    send_data(C_D1, 4, 1'b1);
    chk("R2 bad check field", {24'b0, resp()}, 32'h0);
    send_token(C_OUT, MY_ADDR, 4'd5, 1'b0);
    send_data(C_D1, 4, 1'b1);
    chk("R2 endpoint out of range", {24'b0, resp()}, 32'h0);
    send_token(C_IN, 7'h11, 4'd2, 1'b0);
    chk("R2 foreign IN", {24'b0, resp()}, 32'h0);

    // R3 start of frame
    begin
      logic [10:0] fr;
      fr = 11'h5A3;
      send_pkt({~C_SOF, C_SOF}, 2, {chk_field(fr), fr}, 1'b1);
      chk("R3 frame strobe", {20'b0, sof_valid, sof_frame}, {20'b0, 1'b1, fr});
      @(negedge clk);
      chk("R3 frame held", {20'b0, sof_valid, sof_frame}, {20'b0, 1'b0, fr});
      send_pkt({~C_SOF, C_SOF}, 2, {chk_field(11'h001) ^ 5'h01, 11'h001}, 1'b1);
      chk("R3 bad frame check", {20'b0, sof_valid, sof_frame}, {20'b0, 1'b0, fr});
    end

    // R7 IN responses on endpoint 2
    send_token(C_IN, MY_ADDR, 4'd2, 1'b0);
    chk("R7 IN ready", {20'b0, xfer_ep, resp()}, {20'b0, 4'd2, mk(0, 4'h0, 0, 0, 1)});
    ep_ready[2] = 1'b0;
    send_token(C_IN, MY_ADDR, 4'd2, 1'b0);
    chk("R7 IN not ready", {24'b0, resp()}, 32'(mk(1, C_NAK, 0, 0, 0)));
    ep_stall[2] = 1'b1;
    send_token(C_IN, MY_ADDR, 4'd2, 1'b0);
    chk("R7 IN halted", {24'b0, resp()}, 32'(mk(1, C_STALL, 0, 0, 0)));
    ep_ready = '1; ep_stall = '0;

    // R8 SETUP on endpoint 1 (expects DATA1 before)
    send_token(C_SETUP, MY_ADDR, 4'd1, 1'b0);
    send_data(C_D1, 8, 1'b1);
    chk("R8 setup DATA1 rejected", {24'b0, resp()}, 32'h0);
    send_token(C_SETUP, MY_ADDR, 4'd1, 1'b0);
    send_data(C_D0, 4, 1'b1);
    chk("R8 setup short rejected", {24'b0, resp()}, 32'h0);
    send_token(C_SETUP, MY_ADDR, 4'd1, 1'b0);
    send_data(C_D0, 8, 1'b0);
    chk("R8 R6 setup bad crc", {24'b0, resp()}, 32'h0);
    ep_stall[1] = 1'b1; ep_ready[1] = 1'b0;
    send_token(C_SETUP, MY_ADDR, 4'd1, 1'b0);
    send_data(C_D0, 8, 1'b1);
    chk("R8 setup accepted", {24'b0, resp()}, 32'(mk(1, C_ACK, 0, 1, 0)));
    ep_stall[1] = 1'b0; ep_ready[1] = 1'b1;
    send_token(C_OUT, MY_ADDR, 4'd1, 1'b0);
    send_data(C_D1, 4, 1'b1);
    chk("R8 DATA1 new after setup", {24'b0, resp()}, 32'(mk(1, C_ACK, 1, 0, 0)));
    send_token(C_OUT, MY_ADDR, 4'd1, 1'b0);
    send_data(C_D0, 4, 1'b1);
    chk("R5 DATA0 new next", {24'b0, resp()}, 32'(mk(1, C_ACK, 1, 0, 0)));

    // R9 bus reset: endpoint 1 now expects DATA1; after reset DATA0 is new
    @(negedge clk);
    usb_reset = 1'b1;
    @(negedge clk);
    usb_reset = 1'b0;
    send_token(C_OUT, MY_ADDR, 4'd1, 1'b0);
    send_data(C_D0, 4, 1'b1);
    chk("R9 toggle cleared", {24'b0, resp()}, 32'(mk(1, C_ACK, 1, 0, 0)));

    // R9 bus reset abandons a pending OUT
    send_token(C_OUT, MY_ADDR, 4'd3, 1'b0);
    usb_reset = 1'b1;
    @(negedge clk);
    usb_reset = 1'b0;
    send_data(C_D0, 4, 1'b1);
    chk("R9 pending abandoned", {24'b0, resp()}, 32'h0);

    // R1 data without any token
    send_data(C_D0, 4, 1'b1);
    chk("R1 R4 stray data", {24'b0, resp()}, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule